// File: doc/BRIEF.md
# Prescaled Dual Reload Timer

This block holds two independent 16-bit down-counters. Both advance on a shared time base, which is the system clock divided by a fixed factor (20 by default). Each channel has a live counter and a reload value. When a running counter steps from 1 to 0, the channel raises a sticky zero flag. On the next time-base step the counter takes the reload value again. A channel requests an interrupt while its flag is set and its interrupt enable is on.

Channel 1 also drives a square wave that flips at every zero event. That wave shares an output pin with a high-order address line. A select bit decides which of the two reaches the pin, and the address line is chosen out of reset.

The host reaches the block through a synchronous byte-wide register port. Reads return data one cycle after the request. The 16-bit values move as two bytes, with the low byte first.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, every counter, reload value and control bit is zero, no interrupt is requested, and the shared pin follows `addr_hi_in`.
- R2: Writing the low byte of a 16-bit register only parks it. Writing the high byte then stores both bytes in one step, so a lone low-byte write leaves the stored value unchanged.
- R3: Counters change only on a time-base step, which occurs once every DIV clocks (DIV = 20 by default).
- R4: A running counter at a nonzero value decrements on each step, and the step from 1 to 0 sets the channel's zero flag. A counter at 0 loads its reload value on the next step, and a reload value of 0 holds the counter at 0 with no further zero events.
- R5: With its run bit clear, a channel's counter holds its value indefinitely.
- R6: `irq[i]` is high exactly while channel i's zero flag and interrupt-enable bit are both set.
- R7: A zero flag stays set until the host reads the control/status register while the flag is set and afterwards reads that channel's counter low byte. Reading the counter alone does not clear it.
- R8: Channel 1's wave output starts low and toggles at each of its zero events. With reload value N, toggles are (N+1)*DIV clocks apart.
- R9: With the pin-select bit clear the pin carries `addr_hi_in`. With it set the pin carries channel 1's wave, whatever `addr_hi_in` does.
- R10: Register map:
  - Addresses 0–3 are channel 0's counter low, counter high, reload low and reload high.
  - Addresses 4–7 are the same four registers for channel 1.
  - Address 8 is control/status. Its bit 0 and bit 1 are run0 and run1, bits 2 and 3 are ie0 and ie1, bit 4 is the pin select, bit 6 is flag0 and bit 7 is flag1. The flag bits are read-only.
  - Other addresses read 0.
  - `reg_rvalid` rises the cycle after `reg_rd`, with the data on `reg_rdata`.
  - A high-byte read returns the high byte captured by the most recent low-byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| irq | output | 2 | Per-channel interrupt request |
| addr_hi_in | input | 1 | Address bit that shares the output pin |
| addr_hi_pin | output | 1 | Shared pin: address bit or channel 1 wave |

## Verification
The assertions assume that `reg_addr`, `reg_wdata` and the strobes are synchronous to `clk` and held stable across the sampling edge. They also assume that a read of a counter's high byte is preceded by the matching low-byte read, and that DIV is at least 2, so that a time-base step never lasts two cycles. The stimulus issues a single access per transaction, always changes inputs on the falling edge, and always reads a 16-bit value low byte first. It never mixes a read and a write in one cycle.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int NCH    = 2;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd8;

  typedef struct packed {
    logic [CNT_W-1:0] value;
    logic             hit;
  } step_t;

  // One time-base step of a channel: decrement, or reload from zero.
  function automatic step_t count_step(input logic [CNT_W-1:0] cur,
                                       input logic [CNT_W-1:0] rld);
    step_t s;
    if (cur == '0) begin
      s.value = rld;
      s.hit   = 1'b0;
    end else begin
      s.value = cur - 1'b1;
      s.hit   = (cur == CNT_W'(1));
    end
    return s;
  endfunction
endpackage

// File: rtl/rtmr_prescale.sv
module rtmr_prescale #(
  parameter int DIV = 20
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk) begin
    if (rst)                pcnt_q <= '0;
    else if (pcnt_q == LAST) pcnt_q <= '0;
    else                    pcnt_q <= pcnt_q + 1'b1;
  end

  assign tick = (pcnt_q == LAST);

  generate
    if (DIV > 1) begin : g_chk
      AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);  // R3
    end
  endgenerate
endmodule

// File: rtl/rtmr_channel.sv
module rtmr_channel
  import rtmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             cnt_wr,
  input  logic             rld_wr,
  input  logic             clr_flag,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] rld,
  output logic             flag,
  output logic             zero_evt
);
  logic [CNT_W-1:0] cnt_q, rld_q;
  logic             flag_q;
  step_t            nxt;
  logic             step_en;

  assign nxt      = count_step(cnt_q, rld_q);
  assign step_en  = tick & run & ~cnt_wr;
  assign zero_evt = step_en & nxt.hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cnt_wr)       cnt_q <= wr_val;
      else if (step_en) cnt_q <= nxt.value;
      if (rld_wr)       rld_q <= wr_val;
      if (zero_evt)     flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
    end
  end

  assign cnt  = cnt_q;
  assign rld  = rld_q;
  assign flag = flag_q;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!(tick && run) && !cnt_wr) |=> $stable(cnt_q));  // R5
  AST_CNT_WRITE: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt_q == $past(wr_val)));  // R2
  AST_RELOAD_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && run && !cnt_wr && cnt_q == '0) |=> (cnt_q == $past(rld_q)));  // R4
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import rtmr_pkg::*;
#(
  parameter int DIV = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic [NCH-1:0]    irq,
  input  logic              addr_hi_in,
  output logic              addr_hi_pin
);
  localparam int CTRL_W = 2 * NCH + 1;
  localparam int SEL_B  = 2 * NCH;

  logic                        tick;
  logic [NCH-1:0][CNT_W-1:0]   cnt_v, rld_v;
  logic [NCH-1:0]              flag_v, zero_v, cnt_wr_v, rld_wr_v, clr_v;
  logic [NCH-1:0]              arm_q;
  logic [CTRL_W-1:0]           ctrl_q;
  logic [BYTE_W-1:0]           wr_hold_q, rd_hold_q, rd_byte;
  logic [CNT_W-1:0]            rd_word;
  logic                        wave_q;

  logic is_ctrl, is_tim, ch, is_hi, is_rld;
  assign is_ctrl = (reg_addr == A_CTRL);
  assign is_tim  = ~reg_addr[3];
  assign ch      = reg_addr[2];
  assign is_rld  = reg_addr[1];
  assign is_hi   = reg_addr[0];

  rtmr_prescale #(.DIV(DIV)) u_pre (.clk(clk), .rst(rst), .tick(tick));

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      assign cnt_wr_v[g] = reg_wr & is_tim & is_hi & ~is_rld & (ch == 1'(g));
      assign rld_wr_v[g] = reg_wr & is_tim & is_hi &  is_rld & (ch == 1'(g));
      assign clr_v[g]    = reg_rd & is_tim & ~is_hi & ~is_rld & (ch == 1'(g)) & arm_q[g];

      rtmr_channel u_ch (
        .clk(clk), .rst(rst), .tick(tick),
        .run(ctrl_q[g]),
        .cnt_wr(cnt_wr_v[g]), .rld_wr(rld_wr_v[g]), .clr_flag(clr_v[g]),
        .wr_val({reg_wdata, wr_hold_q}),
        .cnt(cnt_v[g]), .rld(rld_v[g]), .flag(flag_v[g]), .zero_evt(zero_v[g])
      );

      assign irq[g] = flag_v[g] & ctrl_q[NCH + g];

      AST_ZERO_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        zero_v[g] |=> flag_v[g]);  // R4
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_v[g] && !(reg_rd && is_tim && !is_hi && !is_rld && ch == 1'(g)))
          |=> flag_v[g]);  // R7
    end
  endgenerate

  // Channel 1 square wave
  always_ff @(posedge clk) begin
    if (rst)            wave_q <= 1'b0;
    else if (zero_v[1]) wave_q <= ~wave_q;
  end

  AST_WAVE_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    !zero_v[1] |=> $stable(wave_q));  // R8

  assign addr_hi_pin = ctrl_q[SEL_B] ? wave_q : addr_hi_in;

  always_comb begin
    rd_word = is_rld ? rld_v[ch] : cnt_v[ch];
    rd_byte = '0;
    if (is_ctrl)     rd_byte = {flag_v[1], flag_v[0], 1'b0, ctrl_q};
    else if (is_tim) rd_byte = is_hi ? rd_hold_q : rd_word[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      wr_hold_q  <= '0;
      rd_hold_q  <= '0;
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
      arm_q      <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_byte;
      if (reg_wr && is_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
      if (reg_wr && is_tim && !is_hi) wr_hold_q <= reg_wdata;
      if (reg_rd && is_tim && !is_hi) rd_hold_q <= rd_word[CNT_W-1:BYTE_W];
      for (int i = 0; i < NCH; i++) begin
        if (reg_rd && is_ctrl) arm_q[i] <= flag_v[i];
        else if (clr_v[i])     arm_q[i] <= 1'b0;
      end
    end
  end

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);  // R10
endmodule

// File: tb/sim_dual_reload_timer.sv
`timescale 1ns/1ps
module sim_dual_reload_timer;
  localparam int DIV = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       reg_rvalid;
  logic [1:0] irq;
  logic       addr_hi_in = 1'b0;
  logic       addr_hi_pin;

  always #2.5 clk = ~clk;

  dual_reload_timer #(.DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .irq(irq), .addr_hi_in(addr_hi_in), .addr_hi_pin(addr_hi_pin)
  );

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Expected spacing between wave toggles, in clocks.
  function automatic int toggle_gap(input int rld);
    return DIV * (rld + 1);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr8(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd8(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; sb.push_back('{e, tag});
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] base, input logic [15:0] v);
    wr8(base, v[7:0]); wr8(base + 4'd1, v[15:8]);
  endtask

  task automatic rd16(input logic [3:0] base, input logic [15:0] e, input string tag);
    rd8(base, e[7:0], tag); rd8(base + 4'd1, e[15:8], tag);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pops expected bytes as read data appears
  always @(negedge clk) begin
    if (!rst && reg_rvalid) begin
      if (sb.size() == 0) check(1'b0, "R10 unexpected read data", reg_rdata, 0);
      else begin
        item_t it;
        it = sb.pop_front();
        check(reg_rdata == it.exp, it.tag, reg_rdata, it.exp);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    logic p;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(irq == 2'b00, "R1 irq after reset", irq, 0);
    addr_hi_in = 1'b1; #1;
    check(addr_hi_pin == 1'b1, "R1 pin follows address", addr_hi_pin, 1);
    addr_hi_in = 1'b0; #1;
    check(addr_hi_pin == 1'b0, "R1 pin follows address", addr_hi_pin, 0);
    rd16(4'd0, 16'h0000, "R1 cnt0 reset");
    rd16(4'd6, 16'h0000, "R1 rld1 reset");
    rd8(4'd8, 8'h00, "R1 ctrl reset");
    rd8(4'd9, 8'h00, "R10 unmapped address");

    // R2 two-byte writes
    wr16(4'd2, 16'h1234);
    rd16(4'd2, 16'h1234, "R2 rld0 readback");
    wr16(4'd0, 16'hBEEF);
    rd16(4'd0, 16'hBEEF, "R2 cnt0 readback");
    wr8(4'd0, 8'h11);
    rd16(4'd0, 16'hBEEF, "R2 low byte alone no commit");

    // R5 stopped channel holds
    repeat (100) @(negedge clk);
    rd16(4'd0, 16'hBEEF, "R5 stopped counter holds");
    settle();

    // R3 R4 R6 count down to zero
    wr16(4'd2, 16'h0000);
    wr16(4'd0, 16'h0003);
    wr8(4'd8, 8'h05);
    n = 0;
    while (!irq[0] && n < 300) begin @(negedge clk); n++; end
    check(n >= 2 * DIV + 1 && n <= 3 * DIV, "R3 three steps to zero", n, 3 * DIV);
    check(irq[0] == 1'b1, "R6 irq with flag and enable", irq[0], 1);

    // R7 flag clear protocol; R4 reload of zero holds at zero
    repeat (2 * DIV) @(negedge clk);
    rd16(4'd0, 16'h0000, "R4 zero reload holds counter at 0");
    rd8(4'd8, 8'h45, "R7 counter read alone keeps flag");
    settle();
    check(irq[0] == 1'b1, "R7 irq still set", irq[0], 1);
    rd8(4'd0, 8'h00, "R7 counter low read after status");
    settle();
    check(irq[0] == 1'b0, "R7 flag cleared", irq[0], 0);
    rd8(4'd8, 8'h05, "R7 status after clear");
    repeat (3 * DIV) @(negedge clk);
    check(irq[0] == 1'b0, "R4 no event with zero reload", irq[0], 0);

    // R6 interrupt enable off
    wr8(4'd8, 8'h01);
    wr16(4'd0, 16'h0001);
    repeat (3 * DIV) @(negedge clk);
    check(irq[0] == 1'b0, "R6 no irq without enable", irq[0], 0);
    rd8(4'd8, 8'h41, "R6 flag set without enable");
    rd8(4'd0, 8'h00, "R7 clear read");
    rd8(4'd8, 8'h01, "R7 flag cleared again");
    settle();

    // R8 R9 channel 1 wave on the pin
    wr8(4'd8, 8'h00);
    wr16(4'd6, 16'h0004);
    wr16(4'd4, 16'h0004);
    wr8(4'd8, 8'h12);
    addr_hi_in = 1'b1;
    #1;
    check(addr_hi_pin == 1'b0, "R8 wave starts low", addr_hi_pin, 0);
    p = addr_hi_pin; n = 0;
    while (addr_hi_pin == p && n < 500) begin @(negedge clk); n++; end
    for (int k = 0; k < 2; k++) begin
      p = addr_hi_pin; n = 0;
      while (addr_hi_pin == p && n < 500) begin @(negedge clk); n++; end
      check(n == toggle_gap(4), "R8 toggle spacing", n, toggle_gap(4));
    end
    p = addr_hi_pin;
    addr_hi_in = ~addr_hi_in; #1;
    check(addr_hi_pin == p, "R9 wave ignores address bit", addr_hi_pin, p);
    check(irq[1] == 1'b0, "R6 ch1 irq disabled", irq[1], 0);

    // R9 select back to address
    wr8(4'd8, 8'h02);
    addr_hi_in = 1'b0; #1;
    check(addr_hi_pin == 1'b0, "R9 address selected", addr_hi_pin, 0);
    addr_hi_in = 1'b1; #1;
    check(addr_hi_pin == 1'b1, "R9 address selected", addr_hi_pin, 1);
    settle();
    check(sb.size() == 0, "R10 all reads answered", sb.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule